// File: doc/BRIEF.md
# Streaming Depthwise Convolution Engine

This core filters a raster-ordered feature map one channel at a time. Each pixel word carries all channels of one spatial position; every channel is convolved only with its own square kernel, so the output has exactly as many channels as the input and no sum is formed across channels. Kernel size (3, 5 or 7), stride (1 or 2) and the frame's row and column counts are chosen at run time and latched when a frame is started.

Pixels arrive on a valid/ready stream and are kept in a small ring of line buffers. Borders are zero-padded so that stride 1 keeps the spatial size. A bank of parallel lanes, each with its own multiplier and wide accumulator, works through the channels one group at a time and walks the kernel taps one per cycle. Each accumulated sum is rounded to nearest and saturated back to the pixel format. Finished output words leave on a second valid/ready stream with an end-of-frame flag. Coefficients are written through a plain write port, indexed by channel and tap, while the core is idle.

Top module: `dwc_engine`

## Requirements
- R1: After reset `busy`, `inReady` and `outValid` are low.
- R2: A write with `wrEn` high while idle stores `wrData` (signed, 1 integer bit, 9 fractional bits) as the coefficient of channel `wrChan` at tap index ky*7+kx, where ky and kx count kernel row and column from the top-left; later frames use the stored value.
- R3: `cfgKsel` 0, 1 and 2 select a kernel size K of 3, 5 and 7. Channel c sits at bits [8c+7:8c] of both `inData` and `outData`, and each output channel depends only on the same input channel and that channel's coefficients.
- R4: With stride 1 the output is H rows by W columns in raster order. Output (r,c) sums pixel(r-p+ky, c-p+kx) times coefficient(ky,kx) over the K×K taps, with p=(K-1)/2 and pixels outside the frame taken as zero.
- R5: With `cfgStride2` high, and H and W even, only the even-row, even-column positions of the stride-1 grid are produced, giving H/2 by W/2 outputs in raster order.
- R6: Pixels are signed with 2 integer and 6 fractional bits. The result is floor((sum + 256) / 512), so halves round upward, saturated to the range -128..127.
- R7: Exactly H×W input words are accepted per frame, each once, in order. Stalls on `inValid` never drop or repeat a pixel, and `inReady` stays low once the last pixel has been taken.
- R8: `outValid` and `outData` hold steady until `outReady` is seen. `outLast` is high only with the final output word of a frame.
- R9: `start` while idle latches the configuration and raises `busy`. Configuration changes during a frame have no effect, and `busy` falls after the last output has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame with the present configuration |
| cfgKsel | input | 2 | Kernel size code |
| cfgStride2 | input | 1 | Stride 2 when high |
| cfgRows | input | 6 | Frame height H |
| cfgCols | input | 6 | Frame width W (up to 32) |
| busy | output | 1 | Frame in progress |
| wrEn | input | 1 | Coefficient write strobe |
| wrChan | input | 2 | Coefficient channel |
| wrTap | input | 6 | Coefficient tap index ky*7+kx |
| wrData | input | 10 | Coefficient value |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Core accepts input word |
| inData | input | 32 | Input pixel word, all channels |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts output word |
| outLast | output | 1 | Final output word of the frame |
| outData | output | 32 | Output pixel word, all channels |

## Verification
The hardest situation to reach is a window that hangs over the bottom and right edges while the input stream is already exhausted. There the core must keep producing padded outputs from buffered rows alone, with both handshakes stalling at random. The bench drives frames whose size is near, equal to or smaller than the kernel, including a 4×4 frame under a 7×7 kernel and a full 32-column frame. It inserts random gaps on both streams, so the tail outputs are drained under backpressure. Each word is compared against a model built from the requirements, and the bench checks that `busy` falls and `inReady` stays low afterwards.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int PIX_W   = 8;
  localparam int WGT_W   = 10;
  localparam int FRAC_W  = 9;
  localparam int ACC_W   = 24;
  localparam int COORD_W = 5;
  localparam int LB_DEPTH = 1 << COORD_W;
  localparam int SLOT_W  = 3;
  localparam int LB_ROWS = 1 << SLOT_W;
  localparam int TAP_W   = 6;
  localparam int TAP_ROW = 7;
  localparam int GRP_W   = 4;

  typedef struct packed {
    logic                lbWrite;
    logic [SLOT_W-1:0]   wrSlot;
    logic [COORD_W-1:0]  wrCol;
    logic                tapValid;
    logic [SLOT_W-1:0]   tapSlot;
    logic [COORD_W-1:0]  tapCol;
    logic [TAP_W-1:0]    tapIdx;
    logic [GRP_W-1:0]    grp;
    logic                mac;
    logic                macFirst;
    logic                store;
  } dwcStrobe_t;

  function automatic logic [3:0] kernelSize(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd3;
      2'd1:    return 4'd5;
      default: return 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/dwc_lane.sv
module dwc_lane
  import dwc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [PIX_W-1:0] pix,
  input  logic signed [WGT_W-1:0] wgt,
  input  logic                    mac,
  input  logic                    first,
  output logic        [PIX_W-1:0] res
);
  localparam int PROD_W = PIX_W + WGT_W;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (PIX_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(1 << (PIX_W-1));
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1 << (FRAC_W-1));

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt, acc, biased, shifted;

  assign prod    = pix * wgt;
  assign prodExt = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (!rstN)     acc <= '0;
    else if (mac)  acc <= first ? prodExt : acc + prodExt;
  end

  assign biased  = acc + HALF;
  assign shifted = biased >>> FRAC_W;

  always_comb begin
    if (shifted > SAT_HI)      res = SAT_HI[PIX_W-1:0];
    else if (shifted < SAT_LO) res = SAT_LO[PIX_W-1:0];
    else                       res = shifted[PIX_W-1:0];
  end
endmodule

// File: rtl/dwc_ctrl.sv
module dwc_ctrl
  import dwc_pkg::*;
#(
  parameter int GROUPS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           cfgKsel,
  input  logic                 cfgStride2,
  input  logic [COORD_W:0]     cfgRows,
  input  logic [COORD_W:0]     cfgCols,
  input  logic                 inValid,
  input  logic                 outReady,
  output logic                 inReady,
  output logic                 outValid,
  output logic                 outLast,
  output logic                 busy,
  output dwcStrobe_t           strb
);
  localparam int NW = COORD_W + 2;
  localparam int CNT_W = 2 * (COORD_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_CHECK, S_MAC, S_ROUND, S_EMIT, S_ADV} state_t;
  state_t state;

  logic [3:0]        kReg;
  logic [1:0]        padReg;
  logic              s2Reg;
  logic [COORD_W:0]  hReg, wReg;
  logic [NW-1:0]     vr, vc;
  logic [2:0]        ky, kx;
  logic [GRP_W-1:0]  grp;
  logic [CNT_W-1:0]  acceptCnt;

  logic [NW-1:0] padExt, twoPad, hExt, wExt, orow, ocol, sumR, sumC, tRow, tCol;
  logic inRange, outPos, rowOk, colOk, lastCol, lastRow, kxEnd, kyEnd;

  always_comb begin
    padExt  = NW'(padReg);
    twoPad  = NW'({padReg, 1'b0});
    hExt    = NW'(hReg);
    wExt    = NW'(wReg);
    orow    = vr - padExt;
    ocol    = vc - padExt;
    sumR    = vr + NW'(ky);
    sumC    = vc + NW'(kx);
    tRow    = sumR - twoPad;
    tCol    = sumC - twoPad;
    rowOk   = (sumR >= twoPad) && (tRow < hExt);
    colOk   = (sumC >= twoPad) && (tCol < wExt);
    inRange = (vr < hExt) && (vc < wExt);
    outPos  = (vr >= padExt) && (vc >= padExt) && (!s2Reg || (!orow[0] && !ocol[0]));
    lastCol = (vc == wExt - NW'(1) + padExt);
    lastRow = (vr == hExt - NW'(1) + padExt);
    kxEnd   = ({1'b0, kx} == kReg - 4'd1);
    kyEnd   = ({1'b0, ky} == kReg - 4'd1);
  end

  // Strobes to the datapath
  always_comb begin
    strb          = '0;
    strb.lbWrite  = (state == S_STEP) && inRange && inValid;
    strb.wrSlot   = vr[SLOT_W-1:0];
    strb.wrCol    = vc[COORD_W-1:0];
    strb.tapValid = rowOk && colOk;
    strb.tapSlot  = tRow[SLOT_W-1:0];
    strb.tapCol   = tCol[COORD_W-1:0];
    strb.tapIdx   = TAP_W'(ky) * TAP_W'(TAP_ROW) + TAP_W'(kx);
    strb.grp      = grp;
    strb.mac      = (state == S_MAC);
    strb.macFirst = (ky == 3'd0) && (kx == 3'd0);
    strb.store    = (state == S_ROUND);
  end

  assign busy     = (state != S_IDLE);
  assign inReady  = (state == S_STEP) && inRange;
  assign outValid = (state == S_EMIT);
  assign outLast  = outValid
                  && (orow == hExt - NW'({s2Reg, !s2Reg}))
                  && (ocol == wExt - NW'({s2Reg, !s2Reg}));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kReg <= 4'd3; padReg <= 2'd1; s2Reg <= 1'b0;
      hReg <= '0; wReg <= '0; vr <= '0; vc <= '0;
      ky <= '0; kx <= '0; grp <= '0; acceptCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          kReg      <= kernelSize(cfgKsel);
          padReg    <= 2'((kernelSize(cfgKsel) - 4'd1) >> 1);
          s2Reg     <= cfgStride2;
          hReg      <= cfgRows;
          wReg      <= cfgCols;
          vr        <= '0;
          vc        <= '0;
          acceptCnt <= '0;
          state     <= S_STEP;
        end
        S_STEP: begin
          if (!inRange) state <= S_CHECK;
          else if (inValid) begin
            acceptCnt <= acceptCnt + CNT_W'(1);
            state     <= S_CHECK;
          end
        end
        S_CHECK: begin
          ky <= '0; kx <= '0; grp <= '0;
          state <= outPos ? S_MAC : S_ADV;
        end
        S_MAC: begin
          if (kxEnd) begin
            kx <= '0;
            if (kyEnd) begin ky <= '0; state <= S_ROUND; end
            else ky <= ky + 3'd1;
          end else kx <= kx + 3'd1;
        end
        S_ROUND: begin
          if (grp == GRP_W'(GROUPS - 1)) state <= S_EMIT;
          else begin grp <= grp + GRP_W'(1); state <= S_MAC; end
        end
        S_EMIT: if (outReady) state <= S_ADV;
        S_ADV: begin
          state <= S_STEP;
          if (lastCol) begin
            vc <= '0;
            if (lastRow) state <= S_IDLE;
            else vr <= vr + NW'(1);
          end else vc <= vc + NW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: a frame ends only after exactly H*W pixels were taken
  assert_pixel_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ADV && lastCol && lastRow) |-> (acceptCnt == CNT_W'(hReg) * CNT_W'(wReg)));

  // R5: stride-2 outputs lie on the even grid
  assert_even_grid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && s2Reg) |-> (!orow[0] && !ocol[0]));

  // R9: configuration is frozen while a frame runs
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(kReg) && $stable(hReg) && $stable(wReg) && $stable(s2Reg)));
endmodule

// File: rtl/dwc_datapath.sv
module dwc_datapath
  import dwc_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int LANES    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dwcStrobe_t                  strb,
  input  logic [CHANNELS*PIX_W-1:0]   inData,
  input  logic                        wrEn,
  input  logic [$clog2(CHANNELS)-1:0] wrChan,
  input  logic [TAP_W-1:0]            wrTap,
  input  logic [WGT_W-1:0]            wrData,
  output logic [CHANNELS*PIX_W-1:0]   outData
);
  localparam int CH_W   = $clog2(CHANNELS);
  localparam int WORD_W = CHANNELS * PIX_W;
  localparam int TAPS   = 1 << TAP_W;
  localparam int USED_TAPS = TAP_ROW * TAP_ROW;

  logic [WORD_W-1:0] lineBuf [LB_ROWS][LB_DEPTH];
  logic [WGT_W-1:0]  wMem [CHANNELS][TAPS];
  logic [WORD_W-1:0] tapWord;
  logic [CH_W-1:0]   chSel  [LANES];
  logic [PIX_W-1:0]  laneRes [LANES];

  always_ff @(posedge clk) begin
    if (strb.lbWrite) lineBuf[strb.wrSlot][strb.wrCol] <= inData;
  end

  always_ff @(posedge clk) begin
    if (wrEn && (int'(wrTap) < USED_TAPS)) wMem[wrChan][wrTap] <= wrData;
  end

  assign tapWord = lineBuf[strb.tapSlot][strb.tapCol];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic signed [PIX_W-1:0] lanePix;
      logic signed [WGT_W-1:0] laneWgt;
      always_comb begin
        chSel[i] = CH_W'(int'(strb.grp) * LANES + i);
        lanePix  = strb.tapValid ? tapWord[chSel[i]*PIX_W +: PIX_W] : '0;
        laneWgt  = wMem[chSel[i]][strb.tapIdx];
      end
      dwc_lane u_lane (
        .clk   (clk),
        .rstN  (rstN),
        .pix   (lanePix),
        .wgt   (laneWgt),
        .mac   (strb.mac),
        .first (strb.macFirst),
        .res   (laneRes[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) outData <= '0;
    else if (strb.store) begin
      for (int i = 0; i < LANES; i++)
        outData[chSel[i]*PIX_W +: PIX_W] <= laneRes[i];
    end
  end
endmodule

// File: rtl/dwc_engine.sv
module dwc_engine
  import dwc_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int LANES    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [1:0]                    cfgKsel,
  input  logic                          cfgStride2,
  input  logic [COORD_W:0]              cfgRows,
  input  logic [COORD_W:0]              cfgCols,
  output logic                          busy,
  input  logic                          wrEn,
  input  logic [$clog2(CHANNELS)-1:0]   wrChan,
  input  logic [TAP_W-1:0]              wrTap,
  input  logic [WGT_W-1:0]              wrData,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [CHANNELS*PIX_W-1:0]     inData,
  output logic                          outValid,
  input  logic                          outReady,
  output logic                          outLast,
  output logic [CHANNELS*PIX_W-1:0]     outData
);
  localparam int GROUPS = CHANNELS / LANES;

  dwcStrobe_t strb;

  dwc_ctrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgKsel(cfgKsel),
    .cfgStride2(cfgStride2), .cfgRows(cfgRows), .cfgCols(cfgCols),
    .inValid(inValid), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .outLast(outLast), .busy(busy), .strb(strb)
  );

  dwc_datapath #(.CHANNELS(CHANNELS), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .wrEn(wrEn), .wrChan(wrChan), .wrTap(wrTap), .wrData(wrData),
    .outData(outData)
  );

  // R8: an offered output word is held until taken
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R2: coefficients are written only while idle
  assert_wr_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !busy);
endmodule

// File: tb/dwc_engine_test.sv
`timescale 1ns/1ps
module dwc_engine_test;
  localparam int C = 4;
  localparam int P = 2;

  logic clk = 0, rstN = 0, start = 0, cfgStride2 = 0, busy;
  logic [1:0] cfgKsel = 0;
  logic [5:0] cfgRows = 0, cfgCols = 0;
  logic wrEn = 0;
  logic [1:0] wrChan = 0;
  logic [5:0] wrTap = 0;
  logic [9:0] wrData = 0;
  logic inValid = 0, inReady, outValid, outReady = 0, outLast;
  logic [C*8-1:0] inData = 0, outData;

  int errors = 0, checks = 0, cyc = 0;
  int lfsr = 32'h1badcafe;
  int pixM [8][32][C];
  int wtM  [C][49];

  dwc_engine #(.CHANNELS(C), .LANES(P)) uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int rnd();
    lfsr = lfsr * 1103515245 + 12345;
    return (lfsr >>> 16) & 32'h7fff;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model(int ch, int r, int c, int k, int h, int w);
    int p = (k - 1) / 2;
    int sum = 0;
    int v;
    for (int ky = 0; ky < k; ky++)
      for (int kx = 0; kx < k; kx++) begin
        int rr = r - p + ky;
        int cc = c - p + kx;
        if (rr >= 0 && rr < h && cc >= 0 && cc < w)
          sum += pixM[rr][cc][ch] * wtM[ch][ky*7+kx];
      end
    v = (sum + 256) >>> 9;
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return v;
  endfunction

  task automatic loadWeights();
    for (int ch = 0; ch < C; ch++)
      for (int t = 0; t < 49; t++) begin
        @(negedge clk);
        wrEn = 1; wrChan = 2'(ch); wrTap = 6'(t); wrData = 10'(wtM[ch][t]);
      end
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic runFrame(int ksel, bit s2, int h, int w, bit bp, string req);
    int k = 3 + 2 * ksel;
    int s = s2 ? 2 : 1;
    int nOut = (h / s) * (w / s);
    int got = 0;
    bit extra = 0;
    @(negedge clk);
    start = 1; cfgKsel = 2'(ksel); cfgStride2 = s2; cfgRows = 6'(h); cfgCols = 6'(w);
    @(negedge clk);
    start = 0; cfgKsel = 2'(2 - ksel); cfgStride2 = !s2; cfgRows = 6'd2; cfgCols = 6'd3;
    check(busy == 1, "R9", "busy after start", busy, 1);
    fork
      begin : feeder
        int idx = 0;
        while (idx < h * w) begin
          @(negedge clk);
          if (bp && (rnd() % 4 == 0)) inValid = 0;
          else begin
            inValid = 1;
            for (int ch = 0; ch < C; ch++)
              inData[ch*8 +: 8] = 8'(pixM[idx / w][idx % w][ch]);
            if (inReady) idx++;
          end
        end
        @(negedge clk);
        inValid = 0;
        while (busy) begin
          if (inReady) extra = 1;
          @(negedge clk);
        end
      end
      begin : collector
        while (got < nOut) begin
          @(negedge clk);
          outReady = bp ? (rnd() % 3 != 0) : 1'b1;
          if (outValid && outReady) begin
            int orow = (got / (w / s)) * s;
            int ocol = (got % (w / s)) * s;
            logic [C*8-1:0] exp;
            for (int ch = 0; ch < C; ch++)
              exp[ch*8 +: 8] = 8'(model(ch, orow, ocol, k, h, w));
            check(outData == exp, req, $sformatf("word r%0d c%0d", orow, ocol), outData, exp);
            check(outLast == (got == nOut - 1), "R8", "outLast flag", outLast, got == nOut - 1);
            got++;
          end
        end
        @(negedge clk);
        outReady = 0;
      end
    join
    repeat (3) @(negedge clk);
    check(busy == 0, "R9", "busy falls after frame", busy, 0);
    check(!extra && !inReady, "R7", "no input taken after last pixel", extra, 0);
    check(outValid == 0, "R7", "no extra output", outValid, 0);
  endtask

  task automatic fillPix(int mode);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 32; c++)
        for (int ch = 0; ch < C; ch++)
          case (mode)
            0: pixM[r][c][ch] = (rnd() % 256) - 128;
            1: pixM[r][c][ch] = 127;
            2: pixM[r][c][ch] = -128;
            default: pixM[r][c][ch] = ((rnd() % 64) * 2 + 1) - 64;
          endcase
  endtask

  task automatic fillWgt(int mode);
    for (int ch = 0; ch < C; ch++)
      for (int t = 0; t < 49; t++)
        case (mode)
          0: wtM[ch][t] = (rnd() % 1024) - 512;
          1: wtM[ch][t] = 511;
          default: wtM[ch][t] = 0;
        endcase
  endtask

  task automatic testReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && inReady == 0 && outValid == 0, "R1", "outputs in reset",
          {busy, inReady, outValid}, 0);
    rstN = 1;
    @(negedge clk);
    check(busy == 0 && inReady == 0 && outValid == 0, "R1", "outputs after reset",
          {busy, inReady, outValid}, 0);
  endtask

  task automatic testK3Stride1();
    fillPix(0); fillWgt(0); loadWeights();
    runFrame(0, 0, 5, 6, 1, "R3");
  endtask

  task automatic testK5Stride2();
    fillPix(0); fillWgt(0); loadWeights();
    runFrame(1, 1, 6, 8, 1, "R5");
  endtask

  task automatic testK7Small();
    fillPix(0); fillWgt(0); loadWeights();
    runFrame(2, 0, 4, 4, 0, "R4");
  endtask

  task automatic testSaturate();
    fillWgt(1); loadWeights();
    fillPix(1); runFrame(0, 0, 3, 3, 0, "R6");
    fillPix(2); runFrame(0, 0, 3, 3, 1, "R6");
  endtask

  task automatic testRounding();
    // R2 and R6: centre-tap-only coefficients exercise the half-up rounding
    fillWgt(2);
    wtM[0][8] = 256; wtM[1][8] = -256; wtM[2][8] = 1; wtM[3][8] = 511;
    loadWeights();
    fillPix(3);
    runFrame(0, 0, 3, 4, 1, "R6");
  endtask

  task automatic testIsolation();
    // R3: only channel 2 has coefficients, every other output channel must be zero
    fillWgt(2);
    for (int t = 0; t < 49; t++) wtM[2][t] = (rnd() % 1024) - 512;
    loadWeights();
    fillPix(0);
    runFrame(1, 0, 5, 5, 1, "R3");
  endtask

  task automatic testWideRow();
    fillPix(0); fillWgt(0); loadWeights();
    runFrame(0, 1, 4, 32, 1, "R4");
  endtask

  initial begin
    testReset();
    testK3Stride1();
    testK5Stride2();
    testK7Small();
    testSaturate();
    testRounding();
    testIsolation();
    testWideRow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule